// File: doc/BRIEF.md
# Scratchpad Port Arbiter

This block shares one single-ported scratchpad among three clients: a bulk-transfer (DMA) engine, a core's load/store unit and a core's instruction prefetcher. In each cycle at most one of them gets the port. The winner's command is turned into one access on the storage array, and any read data is routed back to the client that asked for it.

The DMA client works on whole 128-byte lines. It can write any subset of a line's eight 16-byte quadwords. The two core clients work on single aligned quadwords. The grant is combinational from the requests, so a client learns in the same cycle whether its command is taken. A client that loses keeps its request up until a later cycle grants it. The prefetcher's current waiting time is exposed as a counter that can be observed.

The storage is a behavioural array of quadwords. Its default size is 16 KB (1024 quadwords). The 18-bit byte address decodes only as many quadword-index bits as the array needs, so higher address bits alias.

Top module: `lsport_arb`

## Requirements
- R1: In any cycle, at most one of `dma_gnt`, `ls_gnt` and `pf_gnt` is high.
- R2: `dma_req` high always gives `dma_gnt` high in the same cycle.
- R3: With `dma_req` low, `ls_req` high gives `ls_gnt` in the same cycle, whatever `pf_req` is. A request that loses stays pending and is granted in a later cycle.
- R4: `pf_gnt` is high only when `pf_req` is high and both `dma_req` and `ls_req` are low.
- R5: A granted DMA read (`dma_we`=0) raises `dma_rvalid` in the next cycle. `dma_rdata[128*i+127:128*i]` then holds the quadword at line base + 16*i, for i = 0..7.
- R6: For a granted DMA write, `dma_qw_en[i]`=1 stores `dma_wdata[128*i+127:128*i]` into quadword i of the line. Quadwords whose enable bit is 0 keep their old contents.
- R7: A granted core read raises its return valid exactly 6 cycles after the grant cycle, with the addressed quadword on its data port. Load/store reads return on `ls_rvalid`/`ls_rdata`, and prefetch reads return on `pf_rvalid`/`pf_rdata`.
- R8: A granted load/store write (`ls_we`=1) stores `ls_wdata` into the addressed quadword and produces no `ls_rvalid` pulse.
- R9: Address bits [3:0] are ignored for core accesses, and bits [6:0] are ignored for DMA accesses.
- R10: `pf_wait` counts the consecutive cycles in which `pf_req` is high and `pf_gnt` is low, and saturates at its all-ones value. In the cycle after a grant, or after a cycle with no prefetch request, it reads 0.
- R11: In the first cycle after reset, all three return valids are low and `pf_wait` is 0.
- R12: Addresses alias modulo the storage size: with the default size, byte address A and byte address A + 0x4000 reach the same quadword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | input | 1 | DMA line request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 18 | DMA byte address; line-granular |
| dma_qw_en | input | 8 | Per-quadword write enables |
| dma_wdata | input | 1024 | DMA write line |
| dma_gnt | output | 1 | DMA granted this cycle |
| dma_rvalid | output | 1 | DMA read line valid |
| dma_rdata | output | 1024 | DMA read line |
| ls_req | input | 1 | Load/store request |
| ls_we | input | 1 | Load/store write (1) or read (0) |
| ls_addr | input | 18 | Load/store byte address; quadword-granular |
| ls_wdata | input | 128 | Store quadword |
| ls_gnt | output | 1 | Load/store granted this cycle |
| ls_rvalid | output | 1 | Load data valid |
| ls_rdata | output | 128 | Load quadword |
| pf_req | input | 1 | Prefetch read request |
| pf_addr | input | 18 | Prefetch byte address; quadword-granular |
| pf_gnt | output | 1 | Prefetch granted this cycle |
| pf_rvalid | output | 1 | Prefetch data valid |
| pf_rdata | output | 128 | Prefetch quadword |
| pf_wait | output | 8 | Consecutive cycles the prefetcher has waited |

## Verification
The assertions assume that every client keeps its request high from the cycle it first loses until the cycle it is granted. They also assume that no request is raised while reset is high. The directed stimulus follows both rules: each scenario changes requests only at falling clock edges, releases a request only after its grant has been seen, and keeps all requests low during reset. Read-back values are predicted from the bench's own record of what it wrote, and addresses outside the storage size are used only where aliasing is the point of the test.

// File: rtl/lsport_pkg.sv
package lsport_pkg;

    // Fixed architectural geometry of the port
    localparam int QW_BITS   = 128;
    localparam int LINE_QW   = 8;
    localparam int LINE_BITS = QW_BITS * LINE_QW;
    localparam int QW_OFF    = 4;          // byte offset bits inside a quadword
    localparam int LOAD_LAT  = 6;          // grant-to-data cycles for core reads

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LINE_RD,
        OP_LINE_WR,
        OP_QW_RD,
        OP_QW_WR
    } op_e;

    // Requester index; lower index wins
    typedef enum logic [1:0] {
        SRC_DMA = 2'd0,
        SRC_LS  = 2'd1,
        SRC_PF  = 2'd2
    } src_e;

    localparam int NUM_SRC = 3;

endpackage

// File: rtl/lsport_prio.sv
module lsport_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    // Index 0 has the highest priority
    for (genvar i = 0; i < N; i++) begin : g_lvl
        if (i == 0) begin : g_top
            assign gnt[i] = req[i];
        end else begin : g_rest
            assign gnt[i] = req[i] & ~(|req[i-1:0]);
        end
    end

endmodule

// File: rtl/lsport_mem.sv
module lsport_mem
    import lsport_pkg::*;
#(
    parameter int MEM_QW = 1024
) (
    input  logic                      clk,
    input  op_e                       op,
    input  logic [$clog2(MEM_QW)-1:0] qidx,
    input  logic [LINE_QW-1:0]        qw_en,
    input  logic [LINE_BITS-1:0]      wline,
    input  logic [QW_BITS-1:0]        wqw,
    output logic [LINE_BITS-1:0]      rline,
    output logic [QW_BITS-1:0]        rqw
);

    localparam int QIDX_W = $clog2(MEM_QW);
    localparam int SUB_W  = $clog2(LINE_QW);

    logic [QW_BITS-1:0] store [MEM_QW];
    logic [QIDX_W-SUB_W-1:0] line_idx;

    assign line_idx = qidx[QIDX_W-1:SUB_W];

    always_ff @(posedge clk) begin
        case (op)
            OP_LINE_WR: begin
                for (int i = 0; i < LINE_QW; i++) begin
                    if (qw_en[i]) begin
                        store[{line_idx, SUB_W'(i)}] <= wline[i*QW_BITS +: QW_BITS];
                    end
                end
            end
            OP_LINE_RD: begin
                for (int i = 0; i < LINE_QW; i++) begin
                    rline[i*QW_BITS +: QW_BITS] <= store[{line_idx, SUB_W'(i)}];
                end
            end
            OP_QW_WR: store[qidx] <= wqw;
            OP_QW_RD: rqw <= store[qidx];
            default: ;
        endcase
    end

endmodule

// File: rtl/lsport_pipe.sv
module lsport_pipe #(
    parameter int DEPTH = 5,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    if (DEPTH == 0) begin : g_wire
        assign out_valid = in_valid;
        assign out_data  = in_data;
    end else begin : g_chain
        logic [DEPTH-1:0] v;
        logic [W-1:0]     d [DEPTH];

        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) v[s] <= 1'b0;
                    else     v[s] <= in_valid;
                    d[s] <= in_data;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) v[s] <= 1'b0;
                    else     v[s] <= v[s-1];
                    d[s] <= d[s-1];
                end
            end
        end

        assign out_valid = v[DEPTH-1];
        assign out_data  = d[DEPTH-1];
    end

endmodule

// File: rtl/lsport_wait_ctr.sv
module lsport_wait_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic         gnt,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (req && !gnt) begin
            if (cnt != '1) cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/lsport_arb.sv
module lsport_arb
    import lsport_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int MEM_QW = 1024,
    parameter int WAIT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dma_req,
    input  logic                 dma_we,
    input  logic [ADDR_W-1:0]    dma_addr,
    input  logic [7:0]           dma_qw_en,
    input  logic [1023:0]        dma_wdata,
    output logic                 dma_gnt,
    output logic                 dma_rvalid,
    output logic [1023:0]        dma_rdata,
    input  logic                 ls_req,
    input  logic                 ls_we,
    input  logic [ADDR_W-1:0]    ls_addr,
    input  logic [127:0]         ls_wdata,
    output logic                 ls_gnt,
    output logic                 ls_rvalid,
    output logic [127:0]         ls_rdata,
    input  logic                 pf_req,
    input  logic [ADDR_W-1:0]    pf_addr,
    output logic                 pf_gnt,
    output logic                 pf_rvalid,
    output logic [127:0]         pf_rdata,
    output logic [WAIT_W-1:0]    pf_wait
);

    localparam int QIDX_W = $clog2(MEM_QW);
    localparam int IDX_HI = QW_OFF + QIDX_W;

    // ---------------- arbitration ----------------
    logic [NUM_SRC-1:0] req_vec;
    logic [NUM_SRC-1:0] gnt_vec;

    assign req_vec[SRC_DMA] = dma_req;
    assign req_vec[SRC_LS]  = ls_req;
    assign req_vec[SRC_PF]  = pf_req;

    lsport_prio #(.N(NUM_SRC)) prio_i (
        .req (req_vec),
        .gnt (gnt_vec)
    );

    assign dma_gnt = gnt_vec[SRC_DMA];
    assign ls_gnt  = gnt_vec[SRC_LS];
    assign pf_gnt  = gnt_vec[SRC_PF];

    // ---------------- command select ----------------
    op_e                mem_op;
    logic [QIDX_W-1:0]  mem_qidx;

    always_comb begin
        mem_op   = OP_IDLE;
        mem_qidx = '0;
        if (dma_gnt) begin
            mem_op   = dma_we ? OP_LINE_WR : OP_LINE_RD;
            mem_qidx = dma_addr[QW_OFF +: QIDX_W];
        end else if (ls_gnt) begin
            mem_op   = ls_we ? OP_QW_WR : OP_QW_RD;
            mem_qidx = ls_addr[QW_OFF +: QIDX_W];
        end else if (pf_gnt) begin
            mem_op   = OP_QW_RD;
            mem_qidx = pf_addr[QW_OFF +: QIDX_W];
        end
    end

    // Offset and aliased upper address bits take no part in decoding
    logic unused_addr_bits;
    assign unused_addr_bits = ^{dma_addr[QW_OFF-1:0], dma_addr[ADDR_W-1:IDX_HI],
                                ls_addr[QW_OFF-1:0],  ls_addr[ADDR_W-1:IDX_HI],
                                pf_addr[QW_OFF-1:0],  pf_addr[ADDR_W-1:IDX_HI]};

    // ---------------- storage ----------------
    logic [LINE_BITS-1:0] mem_rline;
    logic [QW_BITS-1:0]   mem_rqw;

    lsport_mem #(.MEM_QW(MEM_QW)) mem_i (
        .clk   (clk),
        .op    (mem_op),
        .qidx  (mem_qidx),
        .qw_en (dma_qw_en),
        .wline (dma_wdata),
        .wqw   (ls_wdata),
        .rline (mem_rline),
        .rqw   (mem_rqw)
    );

    // ---------------- read return ----------------
    logic rd_line_q;
    logic rd_core_q;
    logic rd_to_pf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_line_q  <= 1'b0;
            rd_core_q  <= 1'b0;
            rd_to_pf_q <= 1'b0;
        end else begin
            rd_line_q  <= dma_gnt & ~dma_we;
            rd_core_q  <= (ls_gnt & ~ls_we) | pf_gnt;
            rd_to_pf_q <= pf_gnt;
        end
    end

    assign dma_rvalid = rd_line_q;
    assign dma_rdata  = mem_rline;

    logic               core_v;
    logic [QW_BITS:0]   core_d;

    lsport_pipe #(.DEPTH(LOAD_LAT - 1), .W(QW_BITS + 1)) ret_pipe_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rd_core_q),
        .in_data   ({rd_to_pf_q, mem_rqw}),
        .out_valid (core_v),
        .out_data  (core_d)
    );

    assign ls_rvalid = core_v & ~core_d[QW_BITS];
    assign pf_rvalid = core_v &  core_d[QW_BITS];
    assign ls_rdata  = core_d[QW_BITS-1:0];
    assign pf_rdata  = core_d[QW_BITS-1:0];

    // ---------------- prefetch wait observation ----------------
    lsport_wait_ctr #(.W(WAIT_W)) wait_i (
        .clk (clk),
        .rst (rst),
        .req (pf_req),
        .gnt (pf_gnt),
        .cnt (pf_wait)
    );

endmodule

// File: rtl/lsport_arb_chk.sv
module lsport_arb_chk
    import lsport_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              dma_req,
    input logic              dma_we,
    input logic              dma_gnt,
    input logic              dma_rvalid,
    input logic              ls_req,
    input logic              ls_we,
    input logic              ls_gnt,
    input logic              ls_rvalid,
    input logic              pf_req,
    input logic              pf_gnt,
    input logic              pf_rvalid,
    input logic [WAIT_W-1:0] pf_wait
);

    p_one_grant_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dma_gnt, ls_gnt, pf_gnt}));

    p_dma_wins_r2: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> dma_gnt);

    p_ls_second_r3: assert property (@(posedge clk) disable iff (rst)
        (ls_req && !dma_req) |-> ls_gnt);

    // Input rule: a losing client keeps asking (R3)
    p_ls_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ls_req && !ls_gnt) |=> ls_req);

    p_pf_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (pf_req && !pf_gnt) |=> pf_req);

    p_pf_last_r4: assert property (@(posedge clk) disable iff (rst)
        pf_gnt |-> (pf_req && !dma_req && !ls_req));

    p_line_ret_r5: assert property (@(posedge clk) disable iff (rst)
        dma_rvalid |-> $past(dma_gnt && !dma_we));

    p_ls_ret_r7: assert property (@(posedge clk) disable iff (rst)
        ls_rvalid |-> $past(ls_gnt && !ls_we, LOAD_LAT));

    p_pf_ret_r7: assert property (@(posedge clk) disable iff (rst)
        pf_rvalid |-> $past(pf_gnt, LOAD_LAT));

    p_store_silent_r8: assert property (@(posedge clk) disable iff (rst)
        $past(ls_gnt && ls_we, LOAD_LAT) |-> !ls_rvalid);

    p_wait_grow_r10: assert property (@(posedge clk) disable iff (rst)
        (pf_req && !pf_gnt && pf_wait != '1) |=> (pf_wait == $past(pf_wait) + 1'b1));

    p_wait_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (!pf_req || pf_gnt) |=> (pf_wait == '0));

    p_reset_state_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dma_rvalid && !ls_rvalid && !pf_rvalid && pf_wait == '0));

endmodule

bind lsport_arb lsport_arb_chk #(.WAIT_W(WAIT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .dma_req    (dma_req),
    .dma_we     (dma_we),
    .dma_gnt    (dma_gnt),
    .dma_rvalid (dma_rvalid),
    .ls_req     (ls_req),
    .ls_we      (ls_we),
    .ls_gnt     (ls_gnt),
    .ls_rvalid  (ls_rvalid),
    .pf_req     (pf_req),
    .pf_gnt     (pf_gnt),
    .pf_rvalid  (pf_rvalid),
    .pf_wait    (pf_wait)
);

// File: tb/lsport_arb_tb_top.sv
module lsport_arb_tb_top;

    localparam int CLK_P = 10;
    localparam int LAT   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dma_req = 0, dma_we = 0;
    logic [17:0]   dma_addr = '0;
    logic [7:0]    dma_qw_en = '0;
    logic [1023:0] dma_wdata = '0;
    logic          dma_gnt, dma_rvalid;
    logic [1023:0] dma_rdata;
    logic          ls_req = 0, ls_we = 0;
    logic [17:0]   ls_addr = '0;
    logic [127:0]  ls_wdata = '0;
    logic          ls_gnt, ls_rvalid;
    logic [127:0]  ls_rdata;
    logic          pf_req = 0;
    logic [17:0]   pf_addr = '0;
    logic          pf_gnt, pf_rvalid;
    logic [127:0]  pf_rdata;
    logic [7:0]    pf_wait;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    lsport_arb dut_i (
        .clk(clk), .rst(rst),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_qw_en(dma_qw_en),
        .dma_wdata(dma_wdata), .dma_gnt(dma_gnt), .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata),
        .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr), .ls_wdata(ls_wdata),
        .ls_gnt(ls_gnt), .ls_rvalid(ls_rvalid), .ls_rdata(ls_rdata),
        .pf_req(pf_req), .pf_addr(pf_addr), .pf_gnt(pf_gnt), .pf_rvalid(pf_rvalid),
        .pf_rdata(pf_rdata), .pf_wait(pf_wait)
    );

    task automatic chk(string tag, logic [1023:0] act, logic [1023:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(int i, int seed);
        return {4{32'(seed * 4096 + i)}};
    endfunction

    function automatic logic [1023:0] mkline(int seed);
        logic [1023:0] l;
        for (int i = 0; i < 8; i++) l[i*128 +: 128] = pat(i, seed);
        return l;
    endfunction

    // Line at byte 0x100 after the DMA scenario: enables 8'hA5 took seed 2
    function automatic logic [1023:0] mixed_line();
        logic [1023:0] l;
        for (int i = 0; i < 8; i++)
            l[i*128 +: 128] = ((8'hA5 >> i) & 1) ? pat(i, 2) : pat(i, 1);
        return l;
    endfunction

    task automatic dma_op(logic we, logic [17:0] a, logic [7:0] en, logic [1023:0] d);
        @(negedge clk);
        dma_req = 1; dma_we = we; dma_addr = a; dma_qw_en = en; dma_wdata = d;
        #1 chk("R2 dma grant", dma_gnt, 1);
        @(negedge clk);
        dma_req = 0;
    endtask

    // Reads a line; the result is sampled in the cycle after the grant
    task automatic dma_read_chk(logic [17:0] a, logic [1023:0] exp, string tag);
        dma_op(0, a, 8'h00, '0);
        chk({tag, " valid"}, dma_rvalid, 1);
        chk({tag, " data"}, dma_rdata, exp);
    endtask

    task automatic core_read(bit use_pf, logic [17:0] a, logic [127:0] exp, string tag);
        @(negedge clk);
        if (use_pf) begin pf_req = 1; pf_addr = a; end
        else begin ls_req = 1; ls_we = 0; ls_addr = a; end
        #1 chk({tag, " grant"}, use_pf ? pf_gnt : ls_gnt, 1);
        for (int k = 1; k <= LAT; k++) begin
            @(negedge clk);
            if (k == 1) begin pf_req = 0; ls_req = 0; end
            if (k < LAT) begin
                chk({tag, " early valid"}, use_pf ? pf_rvalid : ls_rvalid, 0);
            end else begin
                chk({tag, " valid"}, use_pf ? pf_rvalid : ls_rvalid, 1);
                chk({tag, " data"}, use_pf ? pf_rdata : ls_rdata, exp);
            end
        end
    endtask

    task automatic t_reset();
        chk("R11 dma_rvalid", dma_rvalid, 0);
        chk("R11 ls_rvalid", ls_rvalid, 0);
        chk("R11 pf_rvalid", pf_rvalid, 0);
        chk("R11 pf_wait", pf_wait, 0);
    endtask

    task automatic t_line_access();
        dma_op(1, 18'h00100, 8'hFF, mkline(1));
        dma_read_chk(18'h00100, mkline(1), "R5 full line");
        dma_op(1, 18'h00100, 8'hA5, mkline(2));
        dma_read_chk(18'h00100, mixed_line(), "R6 partial enables");
        dma_op(1, 18'h00100, 8'h00, mkline(3));
        dma_read_chk(18'h00100, mixed_line(), "R6 no enables");
    endtask

    task automatic t_core_reads();
        core_read(0, 18'h00130, pat(3, 1), "R7 ls read qw3");
        core_read(0, 18'h00170, pat(7, 2), "R7 ls read qw7");
        core_read(1, 18'h00100, pat(0, 2), "R7 pf read qw0");
    endtask

    task automatic t_store();
        @(negedge clk);
        ls_req = 1; ls_we = 1; ls_addr = 18'h02000; ls_wdata = pat(9, 5);
        #1 chk("R3 store grant", ls_gnt, 1);
        for (int k = 1; k <= LAT + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin ls_req = 0; ls_we = 0; end
            chk("R8 no return for store", ls_rvalid, 0);
        end
        core_read(0, 18'h02000, pat(9, 5), "R8 store readback");
    endtask

    task automatic t_low_bits();
        core_read(0, 18'h0200F, pat(9, 5), "R9 core offset ignored");
        core_read(1, 18'h0013B, pat(3, 1), "R9 pf offset ignored");
        dma_read_chk(18'h0017F, mixed_line(), "R9 dma offset ignored");
    endtask

    task automatic t_alias();
        core_read(0, 18'h06000, pat(9, 5), "R12 alias core");
        dma_read_chk(18'h3C100, mixed_line(), "R12 alias dma");
    endtask

    task automatic t_priority();
        @(negedge clk);
        dma_req = 1; dma_we = 0; dma_addr = 18'h00100;
        ls_req = 1;  ls_we = 0;  ls_addr = 18'h02000;
        pf_req = 1;  pf_addr = 18'h00110;
        #1;
        chk("R1 R2 all asking: dma", dma_gnt, 1);
        chk("R1 all asking: ls", ls_gnt, 0);
        chk("R1 all asking: pf", pf_gnt, 0);
        chk("R10 wait start", pf_wait, 0);
        @(negedge clk);
        dma_req = 0;
        #1;
        chk("R3 ls beats pf", ls_gnt, 1);
        chk("R3 pf held off", pf_gnt, 0);
        chk("R10 wait one", pf_wait, 1);
        @(negedge clk);
        ls_req = 0;
        #1;
        chk("R4 pf alone", pf_gnt, 1);
        chk("R10 wait two", pf_wait, 2);
        // ls granted in cycle 1 returns in cycle 7; pf granted in cycle 2 returns in cycle 8
        for (int c = 3; c <= 8; c++) begin
            @(negedge clk);
            if (c == 3) begin
                pf_req = 0;
                chk("R10 wait cleared", pf_wait, 0);
            end
            if (c == 7) begin
                chk("R3 held ls valid", ls_rvalid, 1);
                chk("R3 held ls data", ls_rdata, pat(9, 5));
            end
            if (c == 8) begin
                chk("R4 held pf valid", pf_rvalid, 1);
                chk("R4 held pf data", pf_rdata, pat(1, 1));
            end
        end
    endtask

    task automatic t_wait_sat();
        @(negedge clk);
        dma_req = 1; dma_we = 0; dma_addr = 18'h00000;
        pf_req = 1;  pf_addr = 18'h00000;
        repeat (300) @(negedge clk);
        chk("R10 wait saturates", pf_wait, 8'hFF);
        chk("R2 dma still wins", dma_gnt, 1);
        dma_req = 0;
        #1 chk("R4 pf after long wait", pf_gnt, 1);
        @(negedge clk);
        pf_req = 0;
        chk("R10 cleared after grant", pf_wait, 0);
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_line_access();
        t_core_reads();
        t_store();
        t_low_bits();
        t_alias();
        t_priority();
        t_wait_sat();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule